// File: doc/BRIEF.md
# Inter-Core Memory Interference Tracker

This block sits next to a shared memory controller and measures, over one interval, how many cycles each core lost because of the other cores. It watches two kinds of event. The first is a request arriving at a bank. Each request names its core, its bank and its row, and says whether the row was already open. The second is a busy cycle on the data bus or a bank. Each busy cycle names the core that owns the resource and gives a mask of the cores waiting for it.

For every bank the block remembers the row that each core would have left open had it run alone. A row conflict on a row that the requester itself last opened is blamed on the core that opened the row now in the buffer. Every cycle in which a core is held back by at least one other core adds one to that core's excess count. A victim-by-culprit matrix adds one for each culprit in that cycle.

The block also counts the cycles of the interval. When the interval-end pulse arrives, it registers three results: the core with the largest excess count, the core that hurt that core most, and an estimate of that core's stand-alone run time (interval cycles minus its excess). It then clears all of its counters. The shadow rows and open-row owners are kept across the boundary.

Top module: `core_interference_tracker`

## Requirements
- R1: After reset every excess and pair count is zero, `resultValid` is low, and `slowCore`, `hurtCore` and `slowAlone` are zero.
- R2: A request with `reqHit` low counts as row interference when three things hold: the bank has an open row, the requester's remembered row for that bank equals `reqRow`, and the open row was opened by a different core. The requester's excess count and pair entry (requester, opener) then each rise by one in the next cycle.
- R3: A request does not count as row interference in any of these cases: `reqHit` is high, the requester's remembered row differs from `reqRow`, or the requester has never accessed that bank. Every valid request updates the requester's remembered row and makes the requester the bank's open-row owner.
- R4: In a cycle with `busyValid` high, every core whose bit is set in `waitMask` (bit i is core i) and that is not `busyOwner` gets one excess cycle and one count in pair entry (that core, `busyOwner`). The owner's own mask bit is ignored.
- R5: A core's excess count rises by at most one per cycle, even when several culprits hit it in the same cycle. Each culprit's pair entry still rises by one. Diagonal pair entries stay zero.
- R6: On `intervalEnd`, `slowCore` takes the index of the largest excess count, with ties going to the lowest index, and `resultValid` goes high and stays high.
- R7: On `intervalEnd`, `hurtCore` takes the index of the largest entry in the row of `slowCore` in the pair matrix. The diagonal is skipped, and ties go to the lowest eligible index.
- R8: On `intervalEnd`, `slowAlone` takes the number of non-boundary cycles since the previous boundary (or since reset) minus the excess count of `slowCore`.
- R9: Every counter, including the interval cycle count, stops at its all-ones value instead of wrapping.
- R10: On the `intervalEnd` cycle the results are taken from the counts before that cycle. All counts then become zero, and events in that cycle are not counted. Remembered rows and open-row owners are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A request reaches a bank this cycle |
| reqCore | input | CIDX_W | Requesting core |
| reqBank | input | BIDX_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqHit | input | 1 | High if the row was already open |
| busyValid | input | 1 | A bus or bank is busy this cycle |
| busyOwner | input | CIDX_W | Core holding the busy resource |
| waitMask | input | NUM_CORES | Cores waiting on that resource, bit i is core i |
| intervalEnd | input | 1 | Interval boundary pulse |
| excessFlat | output | NUM_CORES*CNT_W | Excess count of core i at bits [i*CNT_W +: CNT_W] |
| pairFlat | output | NUM_CORES*NUM_CORES*CNT_W | Pair entry (victim v, culprit c) at [(v*NUM_CORES+c)*CNT_W +: CNT_W] |
| resultValid | output | 1 | At least one boundary has been seen |
| slowCore | output | CIDX_W | Core with the largest excess at the last boundary |
| hurtCore | output | CIDX_W | Main culprit against slowCore |
| slowAlone | output | CNT_W | Stand-alone time estimate of slowCore |

## Verification
A wrong remembered row or open-row owner shows up as a wrong excess or pair count one cycle after the next conflicting request at that bank. So the bench replays conflict patterns before and after boundaries, and checks that the state survives a clear. A faulty saturation or clear path shows up in the counts the cycle after the limit or the boundary. A faulty selection network can only be seen at a boundary, so the bench places boundaries after crafted ties and all-zero intervals, as well as after a long randomized stream. At each boundary it compares all three results against a bench model built from the requirements.

// File: rtl/itrk_pkg.sv
package itrk_pkg;
  // Strobes issued by the interval control to the counting datapath
  typedef struct packed {
    logic latch;   // register the selection results this cycle
    logic clear;   // zero every counter at this edge
  } itrkStrobe_t;
endpackage

// File: rtl/itrk_satcnt.sv
module itrk_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R9: a full counter holds its value until it is cleared
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> count == TOP);

  // R10: a clear always leaves the counter at zero
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/itrk_ctrl.sv
module itrk_ctrl
  import itrk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intervalEnd,
  output itrkStrobe_t      strobe,
  output logic [CNT_W-1:0] sharedCycles,
  output logic             resultValid
);
  always_comb begin
    strobe.latch = intervalEnd;
    strobe.clear = intervalEnd;
  end

  // Cycle count of the running interval; the boundary cycle itself is not counted
  itrk_satcnt #(.CNT_W(CNT_W)) uShared (
    .clk(clk), .rst_n(rst_n), .clr(intervalEnd), .inc(1'b1), .count(sharedCycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           resultValid <= 1'b0;
    else if (strobe.latch) resultValid <= 1'b1;
  end

  // R6: a boundary always leaves results marked valid
  assert_valid_after_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latch |=> resultValid);
endmodule

// File: rtl/itrk_datapath.sv
module itrk_datapath
  import itrk_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int CNT_W     = 16,
  localparam int CIDX_W   = $clog2(NUM_CORES),
  localparam int BIDX_W   = $clog2(NUM_BANKS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  itrkStrobe_t                    strobe,
  input  logic [CNT_W-1:0]               sharedCycles,
  input  logic                           reqValid,
  input  logic [CIDX_W-1:0]              reqCore,
  input  logic [BIDX_W-1:0]              reqBank,
  input  logic [ROW_W-1:0]               reqRow,
  input  logic                           reqHit,
  input  logic                           busyValid,
  input  logic [CIDX_W-1:0]              busyOwner,
  input  logic [NUM_CORES-1:0]           waitMask,
  output logic [NUM_CORES*CNT_W-1:0]     excessFlat,
  output logic [NUM_CORES*NUM_CORES*CNT_W-1:0] pairFlat,
  output logic [CIDX_W-1:0]              slowCore,
  output logic [CIDX_W-1:0]              hurtCore,
  output logic [CNT_W-1:0]               slowAlone
);
  // Remembered row per core per bank, as if each core ran alone
  logic [ROW_W-1:0]  shadowRow [NUM_CORES][NUM_BANKS];
  logic              shadowOk  [NUM_CORES][NUM_BANKS];
  // Core that opened the row currently in each bank's buffer
  logic [CIDX_W-1:0] openOwner [NUM_BANKS];
  logic              openOk    [NUM_BANKS];

  logic                 rowEvt;
  logic [NUM_CORES-1:0] hurtBy [NUM_CORES];  // [victim][culprit]
  logic [NUM_CORES-1:0] victimBit;

  logic [CNT_W-1:0] excessCnt [NUM_CORES];
  logic [CNT_W-1:0] pairCnt   [NUM_CORES][NUM_CORES];

  // ---------------- row-buffer state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++)
        for (int b = 0; b < NUM_BANKS; b++) shadowOk[c][b] <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        openOk[b]    <= 1'b0;
        openOwner[b] <= '0;
      end
    end else if (reqValid) begin
      shadowOk[reqCore][reqBank] <= 1'b1;
      openOk[reqBank]            <= 1'b1;
      openOwner[reqBank]         <= reqCore;
    end
  end

  always_ff @(posedge clk) begin
    if (reqValid) shadowRow[reqCore][reqBank] <= reqRow;
  end

  // ---------------- interference detection ----------------
  always_comb begin
    rowEvt = reqValid && !reqHit && openOk[reqBank] && shadowOk[reqCore][reqBank]
             && (shadowRow[reqCore][reqBank] == reqRow) && (openOwner[reqBank] != reqCore);
    for (int v = 0; v < NUM_CORES; v++) begin
      for (int a = 0; a < NUM_CORES; a++) begin
        hurtBy[v][a] = 1'b0;
        if (v != a) begin
          if (busyValid && waitMask[v] && busyOwner == CIDX_W'(a)) hurtBy[v][a] = 1'b1;
          if (rowEvt && reqCore == CIDX_W'(v) && openOwner[reqBank] == CIDX_W'(a))
            hurtBy[v][a] = 1'b1;
        end
      end
      victimBit[v] = |hurtBy[v];
    end
  end

  // ---------------- counters ----------------
  for (genvar v = 0; v < NUM_CORES; v++) begin : gVictim
    itrk_satcnt #(.CNT_W(CNT_W)) uExc (
      .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .inc(victimBit[v]), .count(excessCnt[v])
    );
    assign excessFlat[v*CNT_W +: CNT_W] = excessCnt[v];

    // R8: a core cannot lose more cycles than the interval has had
    assert_excess_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      excessCnt[v] <= sharedCycles);

    for (genvar a = 0; a < NUM_CORES; a++) begin : gCulprit
      if (v != a) begin : gPair
        itrk_satcnt #(.CNT_W(CNT_W)) uPair (
          .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .inc(hurtBy[v][a]), .count(pairCnt[v][a])
        );
        // R5: a pair entry never runs ahead of the victim's excess count
        assert_pair_le_excess_R5: assert property (@(posedge clk) disable iff (!rst_n)
          pairCnt[v][a] <= excessCnt[v]);
      end else begin : gDiag
        assign pairCnt[v][a] = '0;
      end
      assign pairFlat[(v*NUM_CORES+a)*CNT_W +: CNT_W] = pairCnt[v][a];
    end
  end

  // ---------------- selection (ties to lowest index) ----------------
  logic [CIDX_W-1:0] slowSel, hurtSel;
  logic [CNT_W-1:0]  slowMax, hurtMax;
  logic              hurtFound;

  always_comb begin
    slowSel = '0;
    slowMax = excessCnt[0];
    for (int i = 1; i < NUM_CORES; i++) begin
      if (excessCnt[i] > slowMax) begin
        slowMax = excessCnt[i];
        slowSel = CIDX_W'(i);
      end
    end
    hurtSel   = '0;
    hurtMax   = '0;
    hurtFound = 1'b0;
    for (int j = 0; j < NUM_CORES; j++) begin
      if (CIDX_W'(j) != slowSel && (!hurtFound || pairCnt[slowSel][j] > hurtMax)) begin
        hurtFound = 1'b1;
        hurtMax   = pairCnt[slowSel][j];
        hurtSel   = CIDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slowCore  <= '0;
      hurtCore  <= '0;
      slowAlone <= '0;
    end else if (strobe.latch) begin
      slowCore  <= slowSel;
      hurtCore  <= hurtSel;
      slowAlone <= sharedCycles - slowMax;
    end
  end

  // R7: the reported culprit is never the victim itself once results exist
  assert_culprit_not_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latch |=> hurtCore != slowCore);
endmodule

// File: rtl/core_interference_tracker.sv
module core_interference_tracker
  import itrk_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int CNT_W     = 16,
  localparam int CIDX_W   = $clog2(NUM_CORES),
  localparam int BIDX_W   = $clog2(NUM_BANKS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reqValid,
  input  logic [CIDX_W-1:0]                     reqCore,
  input  logic [BIDX_W-1:0]                     reqBank,
  input  logic [ROW_W-1:0]                      reqRow,
  input  logic                                  reqHit,
  input  logic                                  busyValid,
  input  logic [CIDX_W-1:0]                     busyOwner,
  input  logic [NUM_CORES-1:0]                  waitMask,
  input  logic                                  intervalEnd,
  output logic [NUM_CORES*CNT_W-1:0]            excessFlat,
  output logic [NUM_CORES*NUM_CORES*CNT_W-1:0]  pairFlat,
  output logic                                  resultValid,
  output logic [CIDX_W-1:0]                     slowCore,
  output logic [CIDX_W-1:0]                     hurtCore,
  output logic [CNT_W-1:0]                      slowAlone
);
  itrkStrobe_t      strobe;
  logic [CNT_W-1:0] sharedCycles;

  itrk_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .intervalEnd(intervalEnd),
    .strobe(strobe), .sharedCycles(sharedCycles), .resultValid(resultValid)
  );

  itrk_datapath #(
    .NUM_CORES(NUM_CORES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sharedCycles(sharedCycles),
    .reqValid(reqValid), .reqCore(reqCore), .reqBank(reqBank), .reqRow(reqRow),
    .reqHit(reqHit), .busyValid(busyValid), .busyOwner(busyOwner), .waitMask(waitMask),
    .excessFlat(excessFlat), .pairFlat(pairFlat),
    .slowCore(slowCore), .hurtCore(hurtCore), .slowAlone(slowAlone)
  );
endmodule

// File: tb/core_interference_tracker_test.sv
`timescale 1ns/1ps
module core_interference_tracker_test;
  localparam int NC   = 4;
  localparam int NB   = 4;
  localparam int TCW  = 8;
  localparam int MAXC = (1 << TCW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqHit = 1'b0, busyValid = 1'b0, intervalEnd = 1'b0;
  logic [1:0] reqCore = '0, reqBank = '0, busyOwner = '0;
  logic [7:0] reqRow = '0;
  logic [NC-1:0] waitMask = '0;
  logic [NC*TCW-1:0] excessFlat;
  logic [NC*NC*TCW-1:0] pairFlat;
  logic resultValid;
  logic [1:0] slowCore, hurtCore;
  logic [TCW-1:0] slowAlone;

  int checks = 0;
  int failures = 0;

  // bench model state
  int mExc [NC];
  int mPair [NC][NC];
  int mShared;
  bit mShOk [NC][NB];
  int mSh [NC][NB];
  bit mOpenOk [NB];
  int mOpen [NB];
  int mOwn [NB];
  int eSlow, eHurt, eAlone;
  bit eValid;

  always #2.5 clk = ~clk;

  core_interference_tracker #(.NUM_CORES(NC), .NUM_BANKS(NB), .ROW_W(8), .CNT_W(TCW)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCore(reqCore), .reqBank(reqBank),
    .reqRow(reqRow), .reqHit(reqHit), .busyValid(busyValid), .busyOwner(busyOwner),
    .waitMask(waitMask), .intervalEnd(intervalEnd), .excessFlat(excessFlat),
    .pairFlat(pairFlat), .resultValid(resultValid), .slowCore(slowCore),
    .hurtCore(hurtCore), .slowAlone(slowAlone)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkCounts(input string req);
    for (int i = 0; i < NC; i++) begin
      chk(req, $sformatf("excess[%0d]", i), int'(excessFlat[i*TCW +: TCW]), mExc[i]);
      for (int j = 0; j < NC; j++)
        chk(req, $sformatf("pair[%0d][%0d]", i, j), int'(pairFlat[(i*NC+j)*TCW +: TCW]), mPair[i][j]);
    end
  endtask

  task automatic checkResults(input string rs, input string rh, input string ra);
    chk(rs, "resultValid", int'(resultValid), int'(eValid));
    chk(rs, "slowCore", int'(slowCore), eSlow);
    chk(rh, "hurtCore", int'(hurtCore), eHurt);
    chk(ra, "slowAlone", int'(slowAlone), eAlone);
  endtask

  // One clock of stimulus; model is advanced with the rules of the requirements
  task automatic tick(input bit rv, input int rc, input int rb, input int rr,
                      input bit bv, input int bo, input bit [NC-1:0] wm, input bit ie);
    bit rh;
    bit hb [NC][NC];
    bit anyHit;
    rh = mOpenOk[rb] && (mOpen[rb] == rr);
    reqValid = rv; reqCore = 2'(rc); reqBank = 2'(rb); reqRow = 8'(rr); reqHit = rh;
    busyValid = bv; busyOwner = 2'(bo); waitMask = wm; intervalEnd = ie;
    for (int i = 0; i < NC; i++) for (int j = 0; j < NC; j++) hb[i][j] = 1'b0;
    if (rv && !rh && mOpenOk[rb] && mShOk[rc][rb] && mSh[rc][rb] == rr && mOwn[rb] != rc)
      hb[rc][mOwn[rb]] = 1'b1;
    if (bv) for (int i = 0; i < NC; i++) if (wm[i] && i != bo) hb[i][bo] = 1'b1;
    if (ie) begin
      int best; int hm; bit found;
      best = 0;
      for (int i = 1; i < NC; i++) if (mExc[i] > mExc[best]) best = i;
      found = 1'b0; hm = 0; eHurt = 0;
      for (int j = 0; j < NC; j++)
        if (j != best && (!found || mPair[best][j] > hm)) begin
          found = 1'b1; hm = mPair[best][j]; eHurt = j;
        end
      eSlow = best; eAlone = mShared - mExc[best]; eValid = 1'b1;
      mShared = 0;
      for (int i = 0; i < NC; i++) begin
        mExc[i] = 0;
        for (int j = 0; j < NC; j++) mPair[i][j] = 0;
      end
    end else begin
      if (mShared < MAXC) mShared++;
      for (int i = 0; i < NC; i++) begin
        anyHit = 1'b0;
        for (int j = 0; j < NC; j++) if (hb[i][j]) begin
          anyHit = 1'b1;
          if (mPair[i][j] < MAXC) mPair[i][j]++;
        end
        if (anyHit && mExc[i] < MAXC) mExc[i]++;
      end
    end
    if (rv) begin
      mSh[rc][rb] = rr; mShOk[rc][rb] = 1'b1;
      mOpen[rb] = rr; mOpenOk[rb] = 1'b1; mOwn[rb] = rc;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; busyValid = 1'b0; intervalEnd = 1'b0; reqHit = 1'b0; waitMask = '0;
  endtask

  task automatic req(input int c, input int b, input int r);
    tick(1'b1, c, b, r, 1'b0, 0, '0, 1'b0);
  endtask

  task automatic busy(input int o, input bit [NC-1:0] wm);
    tick(1'b0, 0, 0, 0, 1'b1, o, wm, 1'b0);
  endtask

  task automatic boundary();
    tick(1'b0, 0, 0, 0, 1'b0, 0, '0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mShared = 0; eSlow = 0; eHurt = 0; eAlone = 0; eValid = 1'b0;
    for (int i = 0; i < NC; i++) begin
      mExc[i] = 0;
      for (int j = 0; j < NC; j++) mPair[i][j] = 0;
      for (int b = 0; b < NB; b++) begin mShOk[i][b] = 1'b0; mSh[i][b] = 0; end
    end
    for (int b = 0; b < NB; b++) begin mOpenOk[b] = 1'b0; mOpen[b] = 0; mOwn[b] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    checkCounts("R1");
    checkResults("R1", "R1", "R1");

    // R3: first accesses and a conflict without a remembered row are not counted
    req(0, 0, 5);
    req(1, 0, 9);
    checkCounts("R3");
    // R2: core0 returns to its own row, core1 owns the open row
    req(0, 0, 5);
    checkCounts("R2");
    chk("R2", "excess[0] literal", int'(excessFlat[0 +: TCW]), 1);
    chk("R2", "pair[0][1] literal", int'(pairFlat[1*TCW +: TCW]), 1);
    // R3: hit, and a conflict on a row other than the remembered one
    req(0, 0, 5);
    req(2, 0, 3);
    req(0, 0, 7);
    checkCounts("R3");
    chk("R3", "excess[0] unchanged", int'(excessFlat[0 +: TCW]), 1);

    // R4: bus busy owned by core2, owner's mask bit ignored
    busy(2, 4'b1111);
    checkCounts("R4");
    busy(2, 4'b0100);
    checkCounts("R4");
    chk("R4", "excess[2] literal", int'(excessFlat[2*TCW +: TCW]), 0);

    // R5: row event and busy event hit core1 in the same cycle
    req(1, 1, 4);
    req(3, 1, 6);
    tick(1'b1, 1, 1, 4, 1'b1, 2, 4'b0010, 1'b0);
    checkCounts("R5");

    // R6/R7/R8/R10: boundary with a busy event in the same cycle
    tick(1'b0, 0, 0, 0, 1'b1, 3, 4'b0111, 1'b1);
    checkResults("R6", "R7", "R8");
    checkCounts("R10");
    // R10: remembered rows survive the clear: core0 row 7 bank0, core2 open
    req(2, 0, 3);
    req(0, 0, 7);
    checkCounts("R10");

    // R6/R7 ties: cores 1 and 2 equal, culprits 0 and 2 equal for core1
    boundary();
    busy(0, 4'b0010);
    busy(2, 4'b0010);
    busy(3, 4'b0100);
    busy(3, 4'b0100);
    boundary();
    checkResults("R6", "R7", "R8");
    chk("R6", "tie slowCore literal", int'(slowCore), 1);
    chk("R7", "tie hurtCore literal", int'(hurtCore), 0);
    // all-zero interval
    boundary();
    checkResults("R6", "R7", "R8");
    chk("R7", "idle hurtCore literal", int'(hurtCore), 1);

    // R9: saturation of excess, pairs and the interval cycle count
    for (int k = 0; k < 300; k++) busy(0, 4'b1110);
    checkCounts("R9");
    chk("R9", "excess[1] saturated", int'(excessFlat[1*TCW +: TCW]), MAXC);
    boundary();
    checkResults("R9", "R9", "R9");

    // Mixed randomized stream with periodic boundaries
    for (int k = 0; k < 600; k++) begin
      int c, b, r, o;
      bit rv, bv, ie;
      c = int'($urandom_range(0, NC-1));
      b = int'($urandom_range(0, 1));
      r = int'($urandom_range(0, 2));
      o = int'($urandom_range(0, NC-1));
      rv = ($urandom_range(0, 3) != 0);
      bv = ($urandom_range(0, 2) == 0);
      ie = (k % 75 == 74);
      tick(rv, c, b, r, bv, o, 4'($urandom_range(0, 15)), ie);
      if (ie) checkResults("R6", "R7", "R8");
      if (k % 25 == 0) checkCounts("R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule